// File: doc/BRIEF.md
# Aligned Little-Endian Load/Store Unit

This block is the data-memory port of a processor datapath. It accepts one memory request at a time. A request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a write flag and, for a write, 64 bits of store data. The block holds its own 64-bit-wide, byte-addressed memory. The upper address bits select a memory word, and the low three bits give the byte offset inside that word.

An access is legal only when its address is a whole multiple of its size. A legal store moves the low bytes of the store data into the addressed lanes in little-endian order: the least significant byte goes to the starting address. A legal load returns the addressed bytes right-justified and zero-extended. An illegal (misaligned) request completes with a fault flag, does not write memory, and returns zero.

Requests arrive on a valid/ready channel, and every accepted request produces one response on a second valid/ready channel, one cycle after acceptance. Only one response can be outstanding. While a response waits for `rsp_ready`, the block holds the response unchanged and keeps `req_ready` low. `req_ready` is high whenever no response is pending or the pending response is taken in the same cycle.

Top module: `lsu_aligned`

## Requirements
- R1: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R2: A request faults (`rsp_fault` = 1 in its response) exactly when its address is not a multiple of its access width. Otherwise `rsp_fault` = 0.
- R3: A faulting store leaves every memory byte unchanged, and a faulting load returns `rsp_rdata` = 0.
- R4: A legal store of N bytes at address A writes store-data byte i (bits 8i+7..8i) to address A+i for i < N, and leaves all other bytes unchanged.
- R5: A legal load of N bytes at address A returns the byte at A+i in `rsp_rdata` bits 8i+7..8i for i < N. All bits from 8N upward are zero.
- R6: A request is accepted on a rising edge with `req_valid` and `req_ready` both high, and its response has `rsp_valid` = 1 from the next edge onward.
- R7: While `rsp_valid` = 1 and `rsp_ready` = 0, `req_ready` is 0, and `rsp_rdata` and `rsp_fault` hold their values.
- R8: The response to a store carries `rsp_rdata` = 0.
- R9: After reset, `rsp_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access width code (R1) |
| req_addr | input | $clog2(DEPTH)+3 | Byte address |
| req_wdata | input | 64 | Store data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 64 | Load result, right-justified |
| rsp_fault | output | 1 | Request was misaligned |

## Verification
The bench builds the block with DEPTH = 4, which gives a 32-byte memory with a 5-bit address. At that size, every combination of access width, start address and direction can be swept. After each store, every word of the memory is read back and compared with a byte-array model. Misaligned stores are therefore shown to change nothing, and partial stores are shown to leave their neighbours intact. A separate stall sequence holds `rsp_ready` low for several cycles to test back-pressure.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_Q = 2'd3
  } acc_size_e;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_pkg::*;
(
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  output logic             misaligned,
  output logic [LANES-1:0] lanes
);
  logic [3:0]       nbytes;
  logic [LANES:0]   span_oh;
  logic [LANES-1:0] span_mask;

  always_comb begin
    nbytes     = 4'd1 << size;
    span_oh    = (LANES+1)'(1) << nbytes;
    span_mask  = LANES'(span_oh - (LANES+1)'(1));
    misaligned = |(off & OFF_W'(nbytes - 4'd1));
    lanes      = misaligned ? '0 : LANES'(span_mask << off);
  end
endmodule

// File: rtl/lsu_bank_mem.sv
module lsu_bank_mem
  import lsu_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  be,
  input  logic              re,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [7:0] bank [DEPTH];
    logic [7:0] rd_b;

    always_ff @(posedge clk) begin
      if (we && be[ln]) bank[idx] <= wdata[ln*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd_b <= '0;
      else if (re) rd_b <= bank[idx];
    end

    assign rdata[ln*8 +: 8] = rd_b;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic              squash,
  output logic [DATA_W-1:0] data
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] keep;
  logic [6:0]        nbits;

  always_comb begin
    shifted = word >> {off, 3'b000};
    nbits   = 7'd8 << size;
    keep    = (size == SZ_Q) ? '1 : ((DATA_W'(1) << nbits) - DATA_W'(1));
    data    = squash ? '0 : (shifted & keep);
  end
endmodule

// File: rtl/lsu_aligned.sv
module lsu_aligned
  import lsu_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_fault
);
  acc_size_e         size_in;
  logic [OFF_W-1:0]  off_in;
  logic [IDX_W-1:0]  idx_in;
  logic              bad_align;
  logic [LANES-1:0]  lane_en;
  logic              accept;
  logic              mem_we, mem_re;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;

  logic              vld_q, fault_q, wr_q;
  logic [OFF_W-1:0]  off_q;
  acc_size_e         size_q;

  assign size_in = acc_size_e'(req_size);
  assign off_in  = req_addr[OFF_W-1:0];
  assign idx_in  = req_addr[ADDR_W-1:OFF_W];

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  lsu_align_chk u_chk (
    .size       (size_in),
    .off        (off_in),
    .misaligned (bad_align),
    .lanes      (lane_en)
  );

  assign mem_we    = accept && req_write && !bad_align;
  assign mem_re    = accept && !req_write && !bad_align;
  assign mem_wdata = req_wdata << {off_in, 3'b000};

  lsu_bank_mem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .be    (lane_en),
    .re    (mem_re),
    .idx   (idx_in),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      fault_q <= 1'b0;
      wr_q    <= 1'b0;
      off_q   <= '0;
      size_q  <= SZ_B;
    end else if (accept) begin
      vld_q   <= 1'b1;
      fault_q <= bad_align;
      wr_q    <= req_write;
      off_q   <= off_in;
      size_q  <= size_in;
    end else if (rsp_ready) begin
      vld_q   <= 1'b0;
    end
  end

  lsu_load_extract u_ext (
    .word   (mem_rdata),
    .off    (off_q),
    .size   (size_q),
    .squash (fault_q || wr_q),
    .data   (rsp_rdata)
  );

  assign rsp_valid = vld_q;
  assign rsp_fault = fault_q;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);  // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_fault)));  // R7
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);  // R7
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_rdata == '0));  // R3
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(lane_en) == (1 << req_size)));  // R4
  AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && size_q == SZ_B) |-> (rsp_rdata[63:8] == '0));  // R5
endmodule

// File: tb/sim_lsu_aligned.sv
module sim_lsu_aligned;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int NBYTES = DEPTH * 8;
  localparam int AW = $clog2(DEPTH) + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_size = '0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_fault;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_aligned #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_load(input int a, input int sz);
    logic [63:0] v = '0;
    for (int i = 0; i < (1 << sz); i++) v[i*8 +: 8] = model[a + i];
    return v;
  endfunction

  // one request with the response taken at once; returns data and fault
  task automatic xfer(input logic wr, input int sz, input int a, input logic [63:0] wd,
                      output logic [63:0] rd, output logic flt);
    @(negedge clk);
    chk("R6 req_ready idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_size = 2'(sz);
    req_addr = AW'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 rsp_valid", 64'(rsp_valid), 64'd1);
    rd = rsp_rdata; flt = rsp_fault;
  endtask

  task automatic verify_all(input string tag);
    logic [63:0] rd; logic flt;
    for (int w = 0; w < DEPTH; w++) begin
      xfer(1'b0, 3, w * 8, '0, rd, flt);
      chk(tag, rd, exp_load(w * 8, 3));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd; logic flt; logic [63:0] wd; logic [63:0] hold;
    logic misal;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R9 req_ready after reset", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    // fill memory with quadwords (R1 size 3 = 8 bytes)
    for (int w = 0; w < DEPTH; w++) begin
      wd = {8{8'(w * 16 + 1)}} ^ 64'h0123_4567_89ab_cdef;
      xfer(1'b1, 3, w * 8, wd, rd, flt);
      chk("R8 store response zero", rd, '0);
      for (int i = 0; i < 8; i++) model[w * 8 + i] = wd[i*8 +: 8];
    end
    verify_all("R4 initial fill");

    // store sweep: every size and start address
    for (int sz = 0; sz < 4; sz++) begin
      for (int a = 0; a < NBYTES; a++) begin
        wd = {32'(a * 977 + sz), 32'(32'hA5C3_0000 + a)};
        misal = (a % (1 << sz)) != 0;
        xfer(1'b1, sz, a, wd, rd, flt);
        chk("R2 store fault flag", 64'(flt), 64'(misal));
        chk("R8 store rdata", rd, '0);
        if (!misal)
          for (int i = 0; i < (1 << sz); i++) model[a + i] = wd[i*8 +: 8];
        verify_all(misal ? "R3 faulting store changed memory" : "R4 store lanes");
      end
    end

    // load sweep: every size and start address
    for (int sz = 0; sz < 4; sz++) begin
      for (int a = 0; a < NBYTES; a++) begin
        misal = (a % (1 << sz)) != 0;
        xfer(1'b0, sz, a, '0, rd, flt);
        chk("R2 load fault flag", 64'(flt), 64'(misal));
        if (misal) chk("R3 faulting load data", rd, '0);
        else       chk("R5 load data R1 width", rd, exp_load(a, sz));
      end
    end

    // back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = AW'(12);
    @(negedge clk);
    req_valid = 1'b0;
    hold = rsp_rdata;
    chk("R6 stalled rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R5 stalled data", hold, exp_load(12, 2));
    for (int k = 0; k < 3; k++) begin
      req_valid = 1'b1; req_addr = AW'(0); req_size = 2'd3;
      @(negedge clk);
      chk("R7 req_ready low in stall", 64'(req_ready), 64'd0);
      chk("R7 data held", rsp_rdata, hold);
      chk("R7 valid held", 64'(rsp_valid), 64'd1);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 queued request answered", rsp_rdata, exp_load(0, 3));
    @(negedge clk);
    chk("R7 drained", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule